// File: doc/BRIEF.md
# Passive STN Panel Timing Generator

This block drives a passive STN dot-matrix panel from a stream of pixels. Each beat of the input stream carries one pixel position. The block packs the subpixels into 4-bit words on an upper data bus and a lower data bus. It strobes each word with a shift clock and closes every row with a one-cycle line pulse. It marks the first row of each frame with a frame-start level and inserts a few blank line periods between frames. It also toggles an AC bias output after a programmable count of line pulses.

Four bus formats come from one line and frame sequencer:

- 4-bit single monochrome.
- 8-bit single monochrome.
- 8-bit dual panel, where each shift clock carries a row of the top half and the matching row of the bottom half.
- 4-bit single colour, where R, G and B subpixels run on without a break across word boundaries.

The block samples mode, width and height at the start of each frame. While the enable input is low, every panel output is held low.

Top module: `stn_panel_timing`

## Requirements
- R1: While `enable_i` is low, or after reset, `panel_en_o`, `sclk_o`, `lp_o`, `frame_o`, `bias_o`, `ud_o`, `ld_o` and `pix_ready_o` are all 0. All pending pixels are discarded, and the next enable starts a new frame.
- R2: Each shift clock pulse is high for exactly one cycle and is followed by at least one low cycle. `ud_o`/`ld_o` change only in a cycle where `sclk_o` is high, so they stay stable across its falling edge.
- R3: Mode 0 (4-bit mono) takes one pixel from `pix_i[0]` per beat. It emits width/4 shift clocks per line, with the earliest pixel on `ud_o[3]` and the latest on `ud_o[0]`. `ld_o` is 0.
- R4: Mode 1 (8-bit mono) takes one pixel from `pix_i[0]` per beat and emits width/8 shift clocks per line. Pixels 1 to 4 of each group of eight go on `ud_o[3]` down to `ud_o[0]`, and pixels 5 to 8 go on `ld_o[3]` down to `ld_o[0]`.
- R5: Mode 2 (8-bit dual) takes the top-half pixel from `pix_i[0]` and the bottom-half pixel of the same column from `pix_i[1]`. It emits width/4 shift clocks per line: the top pixels go on `ud_o` and the bottom pixels on `ld_o`, with the earliest on bit 3. A frame has height/2 data lines.
- R6: Mode 3 (4-bit colour) takes R from `pix_i[0]`, G from `pix_i[1]` and B from `pix_i[2]`. It sends R, G, B of pixel 1, then of pixel 2 and so on, four subpixels per shift clock with the earliest on `ud_o[3]`. This gives 3·width/4 shift clocks per line, and `ld_o` is 0.
- R7: After the last shift clock of a line, `lp_o` goes high for exactly one cycle while `sclk_o` is low. Each data line gets one line pulse.
- R8: `frame_o` is high from the start of the first line of a frame through that line's pulse and is low at every other line pulse. A frame has its data lines plus 4 blank line pulses in single-panel modes, or plus 2 in the dual mode.
- R9: `bias_o` toggles on the edge that ends every n-th line pulse, counting blank pulses too, where n is `bias_period_i`. A value of 0 acts as 1.
- R10: `pix_ready_o` is low once a line's last pixel has been taken and stays low through the line pulse. It is also low throughout the blank line periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Panel on; low clears and quiets all outputs |
| mode_i | input | 2 | 0 mono4, 1 mono8, 2 dual8, 3 colour4 |
| width_i | input | 11 | Pixels per line (multiple of 4; of 8 in mode 1) |
| height_i | input | 11 | Panel rows (even and at least 2 in mode 2) |
| bias_period_i | input | 8 | Line pulses between bias toggles |
| pix_valid_i | input | 1 | Stream beat valid |
| pix_i | input | 3 | Beat payload, lanes per mode |
| pix_ready_o | output | 1 | Stream beat accepted when high with valid |
| panel_en_o | output | 1 | Panel enable |
| sclk_o | output | 1 | Shift clock, data taken on falling edge |
| lp_o | output | 1 | Line latch pulse |
| frame_o | output | 1 | Frame start level |
| bias_o | output | 1 | AC bias waveform |
| ud_o | output | 4 | Upper data bus |
| ld_o | output | 4 | Lower data bus |

## Verification
A word completes on the clock edge that brings its last beat into the packer. It appears on `ud_o`/`ld_o` together with a rising `sclk_o` one edge later, and it is held while `sclk_o` falls on the edge after that. The line pulse follows the final falling shift clock by one edge. The bias toggle lands on the edge that ends a line pulse, and all outputs drop on the edge after enable falls. The bench drives inputs and samples every output on the falling clock edge, so each result is read half a cycle after the edge that produced it. The bench compares each word against the next bits taken from a queue filled from the accepted beats. It checks line and frame counts at each line pulse and frame rise, and it compares the bias level against a running count of line pulses in every cycle.

// File: rtl/stn_timing_pkg.sv
package stn_timing_pkg;

  typedef enum logic [1:0] {
    MODE_MONO4  = 2'd0,
    MODE_MONO8  = 2'd1,
    MODE_DUAL8  = 2'd2,
    MODE_COLOR4 = 2'd3
  } panel_mode_e;

  typedef enum logic [2:0] {
    ST_OFF, ST_DATA, ST_LINE, ST_GAP, ST_BLANK
  } seq_state_e;

  function automatic logic [1:0] beat_bits(panel_mode_e m);
    case (m)
      MODE_DUAL8:  return 2'd2;
      MODE_COLOR4: return 2'd3;
      default:     return 2'd1;
    endcase
  endfunction

  function automatic logic [2:0] beat_mask(panel_mode_e m);
    case (m)
      MODE_DUAL8:  return 3'b011;
      MODE_COLOR4: return 3'b111;
      default:     return 3'b001;
    endcase
  endfunction

  function automatic logic [3:0] word_bits(panel_mode_e m);
    case (m)
      MODE_MONO8, MODE_DUAL8: return 4'd8;
      default:                return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/stn_packer.sv
module stn_packer
  import stn_timing_pkg::*;
#(
  parameter int ACC_W = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  panel_mode_e mode_i,
  input  logic        take_i,
  input  logic [2:0]  beat_i,
  output logic        room_o,
  output logic        drained_o,
  output logic        sclk_o,
  output logic [3:0]  ud_o,
  output logic [3:0]  ld_o
);
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc_q, acc_sh, acc_d, ins;
  logic [CNT_W-1:0] cnt_q, cnt_sh, cnt_d;
  logic [CNT_W:0]   room_sum;
  logic [3:0]       w_bits;
  logic [1:0]       k_bits;
  logic             emit, sclk_q;
  logic [7:0]       wd;
  logic [3:0]       ud_d, ld_d;

  always_comb begin
    k_bits   = beat_bits(mode_i);
    w_bits   = word_bits(mode_i);
    room_sum = {1'b0, cnt_q} + (CNT_W+1)'(k_bits);
    room_o   = room_sum <= (CNT_W+1)'(ACC_W);
    emit     = !sclk_q && (cnt_q >= CNT_W'(w_bits));
    acc_sh   = emit ? (acc_q >> w_bits) : acc_q;
    cnt_sh   = emit ? (cnt_q - CNT_W'(w_bits)) : cnt_q;
    ins      = take_i ? (ACC_W'(beat_i & beat_mask(mode_i)) << cnt_sh) : '0;
    acc_d    = acc_sh | ins;
    cnt_d    = cnt_sh + (take_i ? CNT_W'(k_bits) : '0);
    drained_o = (cnt_q == '0) && !sclk_q;
  end

  // earliest subpixel sits at wd[0]; panels take it on bit 3
  always_comb begin
    wd = acc_q[7:0];
    case (mode_i)
      MODE_MONO8: begin
        ud_d = {wd[0], wd[1], wd[2], wd[3]};
        ld_d = {wd[4], wd[5], wd[6], wd[7]};
      end
      MODE_DUAL8: begin
        ud_d = {wd[0], wd[2], wd[4], wd[6]};
        ld_d = {wd[1], wd[3], wd[5], wd[7]};
      end
      default: begin
        ud_d = {wd[0], wd[1], wd[2], wd[3]};
        ld_d = 4'd0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0; cnt_q <= '0; sclk_q <= 1'b0; ud_o <= '0; ld_o <= '0;
    end else if (!en_i) begin
      acc_q <= '0; cnt_q <= '0; sclk_q <= 1'b0; ud_o <= '0; ld_o <= '0;
    end else begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      sclk_q <= emit;
      if (emit) begin
        ud_o <= ud_d;
        ld_o <= ld_d;
      end
    end
  end

  assign sclk_o = sclk_q;

  a_r2_sclk_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |=> !sclk_q);
  a_r2_data_moves_with_sclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && (ud_o != $past(ud_o) || ld_o != $past(ld_o))) |-> sclk_q);
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(ACC_W));
endmodule

// File: rtl/stn_line_seq.sv
module stn_line_seq
  import stn_timing_pkg::*;
#(
  parameter int W_BITS       = 11,
  parameter int H_BITS       = 11,
  parameter int BLANK_SINGLE = 4,
  parameter int BLANK_DUAL   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  panel_mode_e       mode_i,
  input  logic [W_BITS-1:0] width_i,
  input  logic [H_BITS-1:0] height_i,
  input  logic              take_i,
  input  logic              drained_i,
  output panel_mode_e       mode_o,
  output logic              accept_o,
  output logic              lp_o,
  output logic              frame_o
);
  localparam int BLANK_MAX = (BLANK_SINGLE > BLANK_DUAL) ? BLANK_SINGLE : BLANK_DUAL;
  localparam int BLK_W     = $clog2(BLANK_MAX + 1);

  seq_state_e        state_q;
  panel_mode_e       mode_q;
  logic [W_BITS-1:0] width_q, col_q;
  logic [H_BITS-1:0] lines_q, line_q, lines_new;
  logic [BLK_W-1:0]  blk_q, blk_last;
  logic              frame_q;

  assign lines_new = (panel_mode_e'(mode_i) == MODE_DUAL8) ? (height_i >> 1) : height_i;
  assign blk_last  = (mode_q == MODE_DUAL8) ? BLK_W'(BLANK_DUAL - 1) : BLK_W'(BLANK_SINGLE - 1);
  assign accept_o  = (state_q == ST_DATA) && (col_q != width_q);
  assign lp_o      = (state_q == ST_LINE) || (state_q == ST_BLANK);
  assign frame_o   = frame_q;
  assign mode_o    = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF; mode_q <= MODE_MONO4; width_q <= '0; lines_q <= '0;
      col_q <= '0; line_q <= '0; blk_q <= '0; frame_q <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_OFF; frame_q <= 1'b0; col_q <= '0; line_q <= '0; blk_q <= '0;
    end else begin
      case (state_q)
        ST_OFF, ST_BLANK: begin
          if (state_q == ST_OFF || blk_q == blk_last) begin
            mode_q  <= mode_i;
            width_q <= width_i;
            lines_q <= lines_new;
            col_q   <= '0;
            line_q  <= '0;
            frame_q <= 1'b1;
            state_q <= ST_DATA;
          end else begin
            blk_q   <= blk_q + 1'b1;
            state_q <= ST_GAP;
          end
        end
        ST_DATA: begin
          if (take_i) col_q <= col_q + 1'b1;
          if (col_q == width_q && drained_i) state_q <= ST_LINE;
        end
        ST_LINE: begin
          col_q   <= '0;
          frame_q <= 1'b0;
          if (line_q == lines_q - 1'b1) begin
            blk_q   <= '0;
            state_q <= ST_GAP;
          end else begin
            line_q  <= line_q + 1'b1;
            state_q <= ST_DATA;
          end
        end
        default: state_q <= ST_BLANK;
      endcase
    end
  end

  a_r7_lp_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_o |=> !lp_o);
  a_r8_frame_ends_at_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(frame_q) && $past(en_i)) |-> $past(state_q == ST_LINE));
  a_r10_no_take_outside_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (state_q == ST_DATA));
endmodule

// File: rtl/stn_bias.sv
module stn_bias #(
  parameter int N_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              lp_i,
  input  logic [N_BITS-1:0] period_i,
  output logic              wf_o
);
  logic [N_BITS-1:0] cnt_q;
  logic              wf_q, wrap;

  assign wrap = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; wf_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0; wf_q <= 1'b0;
    end else if (lp_i) begin
      if (wrap) begin
        cnt_q <= '0;
        wf_q  <= !wf_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wf_o = wf_q;

  a_r9_toggle_after_lp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(wf_q)) |-> $past(lp_i));
endmodule

// File: rtl/stn_panel_timing.sv
module stn_panel_timing
  import stn_timing_pkg::*;
#(
  parameter int W_BITS = 11,
  parameter int H_BITS = 11,
  parameter int N_BITS = 8,
  parameter int ACC_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [1:0]        mode_i,
  input  logic [W_BITS-1:0] width_i,
  input  logic [H_BITS-1:0] height_i,
  input  logic [N_BITS-1:0] bias_period_i,
  input  logic              pix_valid_i,
  input  logic [2:0]        pix_i,
  output logic              pix_ready_o,
  output logic              panel_en_o,
  output logic              sclk_o,
  output logic              lp_o,
  output logic              frame_o,
  output logic              bias_o,
  output logic [3:0]        ud_o,
  output logic [3:0]        ld_o
);
  panel_mode_e mode_run;
  logic accept, room, drained, take, en_q;

  assign pix_ready_o = enable_i && accept && room;
  assign take        = pix_valid_i && pix_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= enable_i;
  end
  assign panel_en_o = en_q;

  stn_line_seq #(.W_BITS(W_BITS), .H_BITS(H_BITS)) u_seq (
    .clk_i, .rst_ni, .en_i(enable_i), .mode_i(panel_mode_e'(mode_i)),
    .width_i, .height_i, .take_i(take), .drained_i(drained),
    .mode_o(mode_run), .accept_o(accept), .lp_o, .frame_o
  );

  stn_packer #(.ACC_W(ACC_W)) u_pack (
    .clk_i, .rst_ni, .en_i(enable_i), .mode_i(mode_run), .take_i(take),
    .beat_i(pix_i), .room_o(room), .drained_o(drained),
    .sclk_o, .ud_o, .ld_o
  );

  stn_bias #(.N_BITS(N_BITS)) u_bias (
    .clk_i, .rst_ni, .en_i(enable_i), .lp_i(lp_o), .period_i(bias_period_i),
    .wf_o(bias_o)
  );

  a_r1_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !panel_en_o |-> (!sclk_o && !lp_o && !frame_o && !bias_o && ud_o == 4'd0 && ld_o == 4'd0));
  a_r7_lp_without_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_o |-> !sclk_o);
endmodule

// File: tb/stn_panel_timing_test.sv
`timescale 1ns/1ps
module stn_panel_timing_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0, enable_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [10:0] width_i = 11'd16, height_i = 11'd4;
  logic [7:0]  bias_period_i = 8'd1;
  logic        pix_valid_i = 1'b0;
  logic [2:0]  pix_i = 3'd0;
  logic        pix_ready_o, panel_en_o, sclk_o, lp_o, frame_o, bias_o;
  logic [3:0]  ud_o, ld_o;

  stn_panel_timing uut (.*);

  always #2.5 clk_i = !clk_i;

  int vectors = 0, miscompares = 0, frames = 0, pct = 70;
  int m_cur = 0, w_cur = 16, h_cur = 4, p_cur = 1;
  bit sq[$];
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mtag(int m);
    case (m) 0: return "R3"; 1: return "R4"; 2: return "R5"; default: return "R6"; endcase
  endfunction
  function automatic int kbits(int m); return (m == 2) ? 2 : (m == 3) ? 3 : 1; endfunction
  function automatic int wbits(int m); return (m == 1 || m == 2) ? 8 : 4; endfunction
  function automatic int lines_of(int m, int h); return (m == 2) ? h / 2 : h; endfunction
  function automatic int blank_of(int m); return (m == 2) ? 2 : 4; endfunction

  // stream driver: one beat offered per cycle with pct chance
  always @(negedge clk_i) begin
    pix_valid_i = enable_i && (($urandom % 100) < pct);
    pix_i = 3'($urandom);
    #1;
    if (pix_valid_i && pix_ready_o)
      for (int i = 0; i < kbits(m_cur); i++) sq.push_back(pix_i[i]);
  end

  // monitor
  bit prev_sclk = 0, prev_frame = 0, in_frame = 0, exp_wf = 0;
  int lpidx = 0, words = 0, bcnt = 0;
  logic [3:0] held_u, held_l;
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (!panel_en_o) begin
        chk(!sclk_o && !lp_o && !frame_o && !bias_o && ud_o == 0 && ld_o == 0,
            "R1", {sclk_o, lp_o, frame_o, bias_o, ud_o, ld_o}, 0);
        chk(!pix_ready_o, "R1", pix_ready_o, 0);
        in_frame = 0; lpidx = 0; words = 0; bcnt = 0; exp_wf = 0;
      end else begin
        chk(bias_o == exp_wf, "R9", bias_o, exp_wf);
        if (sclk_o && !prev_sclk) begin
          bit s[8];
          logic [3:0] eu, el;
          held_u = ud_o; held_l = ld_o;
          if (sq.size() < wbits(m_cur)) chk(0, mtag(m_cur), sq.size(), wbits(m_cur));
          else begin
            for (int i = 0; i < 8; i++) s[i] = (i < wbits(m_cur)) ? sq.pop_front() : 1'b0;
            case (m_cur)
              1: begin eu = {s[0], s[1], s[2], s[3]}; el = {s[4], s[5], s[6], s[7]}; end
              2: begin eu = {s[0], s[2], s[4], s[6]}; el = {s[1], s[3], s[5], s[7]}; end
              default: begin eu = {s[0], s[1], s[2], s[3]}; el = 4'd0; end
            endcase
            chk(ud_o == eu && ld_o == el, mtag(m_cur), {ud_o, ld_o}, {eu, el});
          end
          words++;
        end
        if (!sclk_o && prev_sclk)
          chk(ud_o == held_u && ld_o == held_l, "R2", {ud_o, ld_o}, {held_u, held_l});
        if (sclk_o && prev_sclk) chk(0, "R2", 1, 0);
        if (frame_o && !prev_frame) begin
          if (in_frame) begin
            chk(lpidx == lines_of(m_cur, h_cur) + blank_of(m_cur), "R8", lpidx,
                lines_of(m_cur, h_cur) + blank_of(m_cur));
            frames++;
          end
          in_frame = 1; lpidx = 0;
        end
        if (lp_o) begin
          chk(!sclk_o, "R7", sclk_o, 0);
          if (in_frame) begin
            int ew;
            chk(frame_o == (lpidx == 0), "R8", frame_o, lpidx == 0);
            ew = (lpidx < lines_of(m_cur, h_cur)) ? w_cur * kbits(m_cur) / wbits(m_cur) : 0;
            chk(words == ew, (ew == 0) ? "R8" : mtag(m_cur), words, ew);
          end
          words = 0; lpidx++; bcnt++;
          if (bcnt >= ((p_cur == 0) ? 1 : p_cur)) begin exp_wf = !exp_wf; bcnt = 0; end
        end
        if (in_frame && lpidx >= lines_of(m_cur, h_cur))
          chk(!pix_ready_o, "R10", pix_ready_o, 0);
      end
      prev_sclk = sclk_o; prev_frame = frame_o;
    end
  end

  task automatic run_mode(int m, int w, int h, int p, int vp);
    @(negedge clk_i);
    enable_i = 1'b0;
    #2 sq.delete();
    m_cur = m; w_cur = w; h_cur = h; p_cur = p; pct = vp;
    mode_i = 2'(m); width_i = 11'(w); height_i = 11'(h); bias_period_i = 8'(p);
    repeat (4) @(negedge clk_i);
    frames = 0;
    enable_i = 1'b1;
    while (frames < 3) @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    chk(!panel_en_o && !sclk_o && !lp_o && !frame_o && !bias_o && ud_o == 0 && ld_o == 0,
        "R1", {panel_en_o, sclk_o, lp_o, frame_o, bias_o}, 0);
    rst_ni = 1'b1;
    run_mode(0, 16, 4, 3, 70);
    run_mode(1, 16, 3, 1, 60);
    run_mode(2, 8, 4, 2, 80);
    run_mode(3, 12, 3, 0, 70);
    run_mode(3, 8, 2, 5, 100);   // back-to-back beats, straddling nibbles
    run_mode(1, 64, 5, 7, 100);
    run_mode(2, 16, 6, 1, 40);
    // drop enable mid-line, then resume with a fresh frame (R1)
    run_mode(0, 32, 3, 2, 90);
    repeat (11) @(negedge clk_i);
    enable_i = 1'b0;
    #2 sq.delete();
    repeat (3) @(negedge clk_i);
    chk(!panel_en_o && ud_o == 0 && !bias_o, "R1", {panel_en_o, ud_o, bias_o}, 0);
    run_mode(0, 32, 3, 2, 90);
    @(negedge clk_i);
    enable_i = 1'b0;
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    done = 1;
    miscompares++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", frames, 3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule